// File: doc/BRIEF.md
# Two-Level Masked Interrupt Arbiter

This block sits between a processor's interrupt sources and a simple CPU model. It takes a vector of maskable request lines, a non-maskable interrupt input and an address-break interrupt input. Each maskable line has a per-source control level of 0 or 1. Two CPU mask bits, I and UI, decide which levels are open. Level-0 sources need I clear. Level-1 sources stay open while I is set, for as long as UI stays clear. When both bits are set, only the non-maskable and address-break sources get through.

Requests are latched as pending. At an instruction boundary, signalled by `insn_done`, the highest-priority eligible request is granted for one cycle. The grant carries a vector number, a one-hot acknowledge for a maskable winner, and the mask values the CPU must load (both set). Every other request remains pending for a later boundary.

The controller has three states. `ST_IDLE` means nothing is eligible. `ST_ARMED` means an eligible request is waiting for a boundary. `ST_GRANT` is the one-cycle grant. The transitions are:
- `ST_IDLE`/`ST_ARMED` → `ST_GRANT` when a winner exists and `insn_done` is high.
- `ST_IDLE` → `ST_ARMED` when a winner exists without a boundary.
- `ST_ARMED` → `ST_IDLE` when eligibility is lost, for example because the mask bits changed.
- `ST_GRANT` → `ST_IDLE` always. Acknowledged pending state is cleared on this transition.

Top module: `irq_mask_arbiter`

## Requirements
- R1: A pending maskable source with control level 0 (`level[k]`=0) can win only when `i_bit` is 0.
- R2: A pending maskable source with control level 1 can win when `i_bit` is 0, or when `i_bit` is 1 and `ui_bit` is 0.
- R3: With `i_bit`=1 and `ui_bit`=1, only the non-maskable or address-break source can be granted (vector below `VEC_BASE`). Maskable requests stay pending.
- R4: Priority runs as follows: non-maskable, then address break, then level-1 maskable sources, then level-0 maskable sources. Within a level, the lower index wins.
- R5: A grant is issued only at a clock edge where `insn_done` is high and the controller is not already granting. It becomes visible in the cycle after that edge.
- R6: While `grant_valid` is high, `new_i` and `new_ui` are both 1.
- R7: While `grant_valid` is low, `new_i` equals `i_bit` and `new_ui` equals `ui_bit`. Clearing I therefore leaves UI unchanged.
- R8: Vector encoding: non-maskable = 1, address break = 2, maskable source k = `VEC_BASE`+k. The vector is 0 when no grant is active.
- R9: Maskable requests and address-break requests are latched while high and held until granted. The non-maskable source is latched on a rising edge of `nmi` only. Requests that lose arbitration are not lost.
- R10: `ack` is one-hot at bit k for exactly the grant cycle of maskable source k, and zero otherwise. A grant lasts one cycle and is followed by at least one cycle without a grant.
- R11: After reset, `grant_valid`, `vector` and `ack` are all 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N | Maskable request lines, level-sensitive |
| level | input | N | Control level per maskable source |
| nmi | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| addr_brk | input | 1 | Address-break interrupt request |
| i_bit | input | 1 | Current I mask bit |
| ui_bit | input | 1 | Current UI mask bit |
| insn_done | input | 1 | Instruction-boundary strobe |
| grant_valid | output | 1 | One-cycle grant |
| vector | output | 6 | Vector number of the granted source |
| ack | output | N | One-hot acknowledge of a maskable winner |
| new_i | output | 1 | I value for the CPU to load |
| new_ui | output | 1 | UI value for the CPU to load |

## Verification
The bench builds the arbiter with N=4 and VEC_BASE=16. This makes it possible to sweep every request mask against every level mask, under all four I/UI combinations and all four non-maskable/address-break combinations. Each case first checks the single boundary grant. It then opens both masks and drains the remaining pending set one boundary at a time, comparing the full grant order against a priority function computed in the bench. A final case holds `nmi` high across many boundaries to confirm edge-only capture.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_GRANT = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_ABRK = 2'd2,
        SRC_MASK = 2'd3
    } src_kind_e;

    localparam int VEC_W = 6;
    localparam logic [VEC_W-1:0] VEC_NMI  = 6'd1;
    localparam logic [VEC_W-1:0] VEC_ABRK = 6'd2;

endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         nmi,
    input  logic         addr_brk,
    input  logic [N-1:0] ack,
    input  logic         clr_nmi,
    input  logic         clr_ab,
    output logic [N-1:0] pend,
    output logic         nmi_pend,
    output logic         ab_pend
);

    logic nmi_prev;
    logic nmi_rise;

    assign nmi_rise = nmi & ~nmi_prev;

    // one latch per maskable line: set while the line is high, cleared by ack
    for (genvar k = 0; k < N; k++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[k] <= 1'b0;
            end else if (ack[k]) begin
                pend[k] <= 1'b0;
            end else if (req[k]) begin
                pend[k] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
            ab_pend  <= 1'b0;
        end else begin
            nmi_prev <= nmi;
            // a fresh edge in the clearing cycle is kept
            nmi_pend <= (nmi_pend & ~clr_nmi) | nmi_rise;
            if (clr_ab) begin
                ab_pend <= 1'b0;
            end else if (addr_brk) begin
                ab_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     level,
    input  logic             nmi_pend,
    input  logic             ab_pend,
    input  logic             i_bit,
    input  logic             ui_bit,
    output logic             win_valid,
    output src_kind_e        win_kind,
    output logic [IDX_W-1:0] win_idx
);

    logic         hi_open;
    logic         lo_open;
    logic [N-1:0] elig_hi;
    logic [N-1:0] elig_lo;
    logic             hi_found;
    logic             lo_found;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;

    // level-1 sources stay open until both mask bits are set
    assign hi_open = ~i_bit | ~ui_bit;
    assign lo_open = ~i_bit;

    for (genvar k = 0; k < N; k++) begin : g_elig
        assign elig_hi[k] = pend[k] &  level[k] & hi_open;
        assign elig_lo[k] = pend[k] & ~level[k] & lo_open;
    end

    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        hi_found = 1'b0;
        lo_found = 1'b0;
        hi_idx   = '0;
        lo_idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (elig_hi[k]) begin
                hi_found = 1'b1;
                hi_idx   = IDX_W'(k);
            end
            if (elig_lo[k]) begin
                lo_found = 1'b1;
                lo_idx   = IDX_W'(k);
            end
        end
    end

    always_comb begin
        win_valid = 1'b1;
        win_kind  = SRC_NONE;
        win_idx   = '0;
        if (nmi_pend) begin
            win_kind = SRC_NMI;
        end else if (ab_pend) begin
            win_kind = SRC_ABRK;
        end else if (hi_found) begin
            win_kind = SRC_MASK;
            win_idx  = hi_idx;
        end else if (lo_found) begin
            win_kind = SRC_MASK;
            win_idx  = lo_idx;
        end else begin
            win_valid = 1'b0;
        end
    end

endmodule

// File: rtl/irq_grant_fsm.sv
module irq_grant_fsm
    import irq_arb_pkg::*;
#(
    parameter int N        = 8,
    parameter int IDX_W    = 3,
    parameter int VEC_BASE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             win_valid,
    input  src_kind_e        win_kind,
    input  logic [IDX_W-1:0] win_idx,
    output logic             grant_valid,
    output logic [VEC_W-1:0] vector,
    output logic [N-1:0]     ack,
    output logic             clr_nmi,
    output logic             clr_ab
);

    arb_state_e state_q;
    arb_state_e state_d;
    src_kind_e  kind_q;
    logic       take;
    logic [VEC_W-1:0] win_vec;

    assign take = (state_q != ST_GRANT) && win_valid && insn_done;

    always_comb begin
        unique case (win_kind)
            SRC_NMI:  win_vec = VEC_NMI;
            SRC_ABRK: win_vec = VEC_ABRK;
            SRC_MASK: win_vec = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
            default:  win_vec = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ARMED: begin
                if (take) begin
                    state_d = ST_GRANT;
                end else if (win_valid) begin
                    state_d = ST_ARMED;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vector <= '0;
            ack    <= '0;
            kind_q <= SRC_NONE;
        end else if (take) begin
            vector <= win_vec;
            ack    <= (win_kind == SRC_MASK) ? (N'(1) << win_idx) : '0;
            kind_q <= win_kind;
        end else begin
            vector <= '0;
            ack    <= '0;
            kind_q <= SRC_NONE;
        end
    end

    assign grant_valid = (state_q == ST_GRANT);
    assign clr_nmi     = grant_valid && (kind_q == SRC_NMI);
    assign clr_ab      = grant_valid && (kind_q == SRC_ABRK);

endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N        = 8,
    parameter int VEC_BASE = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] level,
    input  logic         nmi,
    input  logic         addr_brk,
    input  logic         i_bit,
    input  logic         ui_bit,
    input  logic         insn_done,
    output logic         grant_valid,
    output logic [5:0]   vector,
    output logic [N-1:0] ack,
    output logic         new_i,
    output logic         new_ui
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     pend;
    logic             nmi_pend;
    logic             ab_pend;
    logic             clr_nmi;
    logic             clr_ab;
    logic             win_valid;
    src_kind_e        win_kind;
    logic [IDX_W-1:0] win_idx;

    irq_pend_capture #(.N(N)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .nmi      (nmi),
        .addr_brk (addr_brk),
        .ack      (ack),
        .clr_nmi  (clr_nmi),
        .clr_ab   (clr_ab),
        .pend     (pend),
        .nmi_pend (nmi_pend),
        .ab_pend  (ab_pend)
    );

    irq_prio_select #(.N(N), .IDX_W(IDX_W)) u_sel (
        .pend      (pend),
        .level     (level),
        .nmi_pend  (nmi_pend),
        .ab_pend   (ab_pend),
        .i_bit     (i_bit),
        .ui_bit    (ui_bit),
        .win_valid (win_valid),
        .win_kind  (win_kind),
        .win_idx   (win_idx)
    );

    irq_grant_fsm #(.N(N), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done   (insn_done),
        .win_valid   (win_valid),
        .win_kind    (win_kind),
        .win_idx     (win_idx),
        .grant_valid (grant_valid),
        .vector      (vector),
        .ack         (ack),
        .clr_nmi     (clr_nmi),
        .clr_ab      (clr_ab)
    );

    // on a grant the CPU loads both mask bits set; otherwise the bits pass through
    assign new_i  = grant_valid | i_bit;
    assign new_ui = grant_valid | ui_bit;

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
    parameter int N        = 8,
    parameter int VEC_BASE = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         grant_valid,
    input logic [5:0]   vector,
    input logic [N-1:0] ack,
    input logic         insn_done,
    input logic         i_bit,
    input logic         ui_bit
);

    assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    assert_ack_in_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0) |-> grant_valid);

    assert_grant_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    assert_grant_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(insn_done));

    assert_masked_only_nmi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid) && $past(i_bit) && $past(ui_bit)) |-> (int'(vector) < VEC_BASE));

    assert_vec_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (vector == '0));

    assert_vec_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (vector != '0));

endmodule

bind irq_mask_arbiter irq_arb_checker #(.N(N), .VEC_BASE(VEC_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .vector      (vector),
    .ack         (ack),
    .insn_done   (insn_done),
    .i_bit       (i_bit),
    .ui_bit      (ui_bit)
);

// File: tb/irq_mask_arbiter_tb.sv
`timescale 1ns/1ps
module irq_mask_arbiter_tb_top;

    localparam int N  = 4;
    localparam int VB = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] level = '0;
    logic         nmi = 1'b0;
    logic         addr_brk = 1'b0;
    logic         i_bit = 1'b0;
    logic         ui_bit = 1'b0;
    logic         insn_done = 1'b0;
    logic         grant_valid;
    logic [5:0]   vector;
    logic [N-1:0] ack;
    logic         new_i;
    logic         new_ui;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_mask_arbiter #(.N(N), .VEC_BASE(VB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .level(level), .nmi(nmi),
        .addr_brk(addr_brk), .i_bit(i_bit), .ui_bit(ui_bit), .insn_done(insn_done),
        .grant_valid(grant_valid), .vector(vector), .ack(ack),
        .new_i(new_i), .new_ui(new_ui)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // bench-side priority function
    function automatic int ref_win(input bit pn, input bit pa, input logic [N-1:0] p,
                                   input logic [N-1:0] l, input bit iv, input bit uv);
        if (pn) return 1;
        if (pa) return 2;
        for (int k = 0; k < N; k++)
            if (p[k] && l[k] && (!iv || !uv)) return VB + k;
        for (int k = 0; k < N; k++)
            if (p[k] && !l[k] && !iv) return VB + k;
        return 0;
    endfunction

    task automatic scenario(input bit nm, input bit ab, input logic [N-1:0] r,
                            input logic [N-1:0] l, input bit iv, input bit uv);
        bit           pn = nm;
        bit           pa = ab;
        logic [N-1:0] pr = r;
        int           e;
        string        tag;
        req = r; level = l; i_bit = iv; ui_bit = uv; nmi = nm; addr_brk = ab; insn_done = 0;
        tick();
        req = '0; addr_brk = 0;
        chk(grant_valid == 0, "R5 no grant without boundary", grant_valid, 0);
        chk(new_i == iv, "R7 new_i passthrough", new_i, iv);
        chk(new_ui == uv, "R7 new_ui passthrough", new_ui, uv);
        tick();
        chk(grant_valid == 0, "R5 still waiting", grant_valid, 0);
        insn_done = 1;
        tick();
        insn_done = 0;
        e = ref_win(pn, pa, pr, l, iv, uv);
        tag = (iv && uv) ? "R3 masked winner" : (iv ? "R2 level1 winner" : "R1 open winner");
        chk(grant_valid == (e != 0), tag, grant_valid, e != 0);
        chk(int'(vector) == e, "R8 vector", vector, e);
        if (e != 0) begin
            chk(new_i && new_ui, "R6 masks set on grant", {new_i, new_ui}, 3);
        end
        chk(int'(ack) == ((e >= VB) ? (1 << (e - VB)) : 0), "R10 ack", ack,
            (e >= VB) ? (1 << (e - VB)) : 0);
        if (e == 1) pn = 0;
        else if (e == 2) pa = 0;
        else if (e >= VB) pr[e - VB] = 1'b0;
        tick();
        chk(grant_valid == 0, "R10 one-cycle grant", grant_valid, 0);
        i_bit = 0; ui_bit = 0; nmi = 0;
        for (int it = 0; it < N + 3; it++) begin
            insn_done = 1;
            tick();
            insn_done = 0;
            e = ref_win(pn, pa, pr, l, 0, 0);
            chk(int'(vector) == e && grant_valid == (e != 0),
                "R4 R9 drain order", vector, e);
            if (e == 1) pn = 0;
            else if (e == 2) pa = 0;
            else if (e >= VB) pr[e - VB] = 1'b0;
            tick();
            if (e == 0) break;
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int cnt;
        @(negedge clk);
        @(negedge clk);
        chk(grant_valid == 0 && vector == 0 && ack == 0, "R11 reset outputs", vector, 0);
        rst_n = 1;
        insn_done = 1;
        tick();
        chk(grant_valid == 0, "R11 nothing pending", grant_valid, 0);
        insn_done = 0;
        tick();
        for (int f = 0; f < 4; f++)
            for (int m = 0; m < 4; m++)
                for (int r = 0; r < 16; r++)
                    for (int l = 0; l < 16; l++)
                        scenario(f[1], f[0], N'(r), N'(l), m[1], m[0]);
        // nmi held high: only one capture
        nmi = 1; i_bit = 1; ui_bit = 1; insn_done = 1;
        cnt = 0;
        for (int t = 0; t < 8; t++) begin
            tick();
            if (grant_valid) begin
                cnt++;
                chk(vector == 1, "R9 nmi vector", vector, 1);
            end
        end
        chk(cnt == 1, "R9 nmi edge only", cnt, 1);
        nmi = 0; insn_done = 0;
        tick();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule